// File: doc/BRIEF.md
# Level-One Cache Hit Detection with Late Doubleword Select

This block is the lookup datapath of a level-one cache that answers a read in a single cycle. A request (valid flag, set index, logical tag) is registered in the address cycle. In the following access cycle the block reads three things at the same moment from the registered index: four 8-byte doublewords, one per way; four directory entries; and four translation entries. It then decides which way, if any, holds the data.

The hit decision uses two groups of compares. The first group compares the logical tag against the logical tag of each of the four translation ways. The second group is a 4x4 matrix of absolute-address compares, one for each pair of directory way and translation way.

- Directory way d hits when some translation way t both matches logically and has an absolute address equal to directory way d's.
- The winning way drives a one-hot late-select line in the access cycle. That line picks the doubleword.
- The hit flag, a multi-hit error flag and the selected doubleword are then captured in output registers.

Every equality compare is reduced by a two-level AND tree: first groups of six bit-matches, then one AND over the group results.

The storage arrays are simple register arrays inside the block. They are loaded through one fill port, which writes a directory entry, a translation entry or a data doubleword on a clock edge.

Top module: `l1_late_select`

## Requirements
- R1: While reset is high and on the first cycle after it, `hit_o`, `multi_o`, `data_o` and `late_sel_o` are all zero, and every directory and translation entry is invalid.
- R2: A request sampled at clock edge k drives `late_sel_o` in the cycle after edge k. Its `hit_o`, `multi_o` and `data_o` appear after edge k+1.
- R3: A translation way matches logically only when all 52 bits of its logical tag equal `req_ltag`. A difference in any single bit, including bit 0 and bit 51, gives no match.
- R4: Directory way d hits when at least one translation way t matches logically and the 26-bit absolute addresses of directory way d and translation way t are equal. An absolute match with a translation way that does not match logically does not count.
- R5: Bit d of `late_sel_o` selects way d, and `late_sel_o` never has more than one bit set. On a hit, `data_o` is the doubleword stored for the selected way at the requested index.
- R6: An entry written with its valid bit at 0 never takes part in a match, whatever its address fields hold.
- R7: When two or more directory ways hit, `multi_o` is 1 and `hit_o` is 1. The lowest-numbered hitting way is selected.
- R8: When no way hits, `late_sel_o` is zero, and the following cycle has `hit_o` = 0, `multi_o` = 0 and `data_o` = 0.
- R9: A cycle with `req_valid` low produces the same outputs as a miss (R8), whatever the other request inputs hold.
- R10: The fill port writes on a clock edge when `wr_en` is 1. The target is chosen by `wr_kind`: 0 for a directory entry, 1 for a translation entry, 2 for a data doubleword. A request captured at the same edge as a fill already sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present in the address cycle |
| req_idx | input | 4 | Set index of the request |
| req_ltag | input | 52 | Logical tag of the request |
| wr_en | input | 1 | Fill write enable |
| wr_kind | input | 2 | Fill target: 0 directory, 1 translation, 2 data |
| wr_way | input | 2 | Way written by the fill |
| wr_idx | input | 4 | Set written by the fill |
| wr_valid | input | 1 | Valid bit written into a directory or translation entry |
| wr_ltag | input | 52 | Logical tag written into a translation entry |
| wr_abs | input | 26 | Absolute address written into a directory or translation entry |
| wr_data | input | 64 | Doubleword written into the data array |
| late_sel_o | output | 4 | One-hot late select of the access cycle |
| hit_o | output | 1 | Registered hit flag |
| multi_o | output | 1 | Registered multi-hit error flag |
| data_o | output | 64 | Registered selected doubleword, zero on a miss |

## Verification
The hardest cases to reach are the cross terms of the absolute-compare matrix. In those cases a directory way equals a translation way that does not match logically, while another pair does match. Only the correct pairing may win.

The stimulus loads one set so that translation ways 1 and 3 carry different logical tags and different absolute addresses, with each matching a different directory way. It then requests each tag in turn, and a third tag that matches neither.

Multi-hit cases are built by loading the same absolute address into several directory ways. A fill is issued on the same edge as a request to reach the write-then-read ordering.

// File: rtl/l1ls_pkg.sv
package l1ls_pkg;
    localparam int N_WAYS      = 4;
    localparam int LTAG_W_DEF  = 52;
    localparam int ABS_W_DEF   = 26;
    localparam int DW_W_DEF    = 64;
    localparam int IDX_W_DEF   = 4;
    localparam int GRP1_DEF    = 6;
    localparam int WAY_W       = $clog2(N_WAYS);

    typedef enum logic [1:0] {
        FILL_DIR  = 2'd0,
        FILL_TLB  = 2'd1,
        FILL_DATA = 2'd2
    } fill_kind_e;

    typedef struct packed {
        logic              hit;
        logic              multi;
        logic [N_WAYS-1:0] sel;
    } lookup_t;

    // keep only the lowest set bit of the way-hit vector
    function automatic logic [N_WAYS-1:0] lowest_way(input logic [N_WAYS-1:0] v);
        logic [N_WAYS-1:0] r;
        r = '0;
        for (int i = N_WAYS - 1; i >= 0; i--) begin
            if (v[i]) r = '0;
            if (v[i]) r[i] = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/lk_cmp2.sv
module lk_cmp2 #(
    parameter int W    = 30,
    parameter int GRP1 = 6
) (
    input  logic         en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         match
);
    localparam int NG = (W + GRP1 - 1) / GRP1;
    localparam int PW = NG * GRP1;

    logic [PW-1:0] bit_eq;
    logic [NG-1:0] grp_eq;

    always_comb begin
        bit_eq        = '1;
        bit_eq[W-1:0] = ~(a ^ b);
    end

    for (genvar g = 0; g < NG; g++) begin : g_lvl1
        assign grp_eq[g] = &bit_eq[g*GRP1 +: GRP1];
    end

    assign match = en & (&grp_eq);
endmodule

// File: rtl/lk_store.sv
module lk_store
    import l1ls_pkg::*;
#(
    parameter int IDX_W  = IDX_W_DEF,
    parameter int LTAG_W = LTAG_W_DEF,
    parameter int ABS_W  = ABS_W_DEF,
    parameter int DW_W   = DW_W_DEF
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  fill_kind_e                     wr_kind,
    input  logic [WAY_W-1:0]               wr_way,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic                           wr_valid,
    input  logic [LTAG_W-1:0]              wr_ltag,
    input  logic [ABS_W-1:0]               wr_abs,
    input  logic [DW_W-1:0]                wr_data,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [N_WAYS-1:0]              dir_v,
    output logic [N_WAYS-1:0][ABS_W-1:0]   dir_abs,
    output logic [N_WAYS-1:0]              tlb_v,
    output logic [N_WAYS-1:0][LTAG_W-1:0]  tlb_ltag,
    output logic [N_WAYS-1:0][ABS_W-1:0]   tlb_abs,
    output logic [N_WAYS-1:0][DW_W-1:0]    dw
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < N_WAYS; w++) begin : g_way
        logic [SETS-1:0]   dv_m;
        logic [SETS-1:0]   tv_m;
        logic [ABS_W-1:0]  da_m [SETS];
        logic [ABS_W-1:0]  ta_m [SETS];
        logic [LTAG_W-1:0] tl_m [SETS];
        logic [DW_W-1:0]   dd_m [SETS];
        logic              hit_way;

        assign hit_way = wr_en && (wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                dv_m <= '0;
                tv_m <= '0;
            end else if (hit_way && wr_kind == FILL_DIR) begin
                dv_m[wr_idx] <= wr_valid;
            end else if (hit_way && wr_kind == FILL_TLB) begin
                tv_m[wr_idx] <= wr_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_way && wr_kind == FILL_DIR) da_m[wr_idx] <= wr_abs;
            if (hit_way && wr_kind == FILL_TLB) begin
                ta_m[wr_idx] <= wr_abs;
                tl_m[wr_idx] <= wr_ltag;
            end
            if (hit_way && wr_kind == FILL_DATA) dd_m[wr_idx] <= wr_data;
        end

        assign dir_v[w]    = dv_m[rd_idx];
        assign dir_abs[w]  = da_m[rd_idx];
        assign tlb_v[w]    = tv_m[rd_idx];
        assign tlb_abs[w]  = ta_m[rd_idx];
        assign tlb_ltag[w] = tl_m[rd_idx];
        assign dw[w]       = dd_m[rd_idx];
    end
endmodule

// File: rtl/lk_match.sv
module lk_match
    import l1ls_pkg::*;
#(
    parameter int LTAG_W = LTAG_W_DEF,
    parameter int ABS_W  = ABS_W_DEF,
    parameter int GRP1   = GRP1_DEF
) (
    input  logic                           req_v,
    input  logic [LTAG_W-1:0]              req_ltag,
    input  logic [N_WAYS-1:0]              dir_v,
    input  logic [N_WAYS-1:0][ABS_W-1:0]   dir_abs,
    input  logic [N_WAYS-1:0]              tlb_v,
    input  logic [N_WAYS-1:0][LTAG_W-1:0]  tlb_ltag,
    input  logic [N_WAYS-1:0][ABS_W-1:0]   tlb_abs,
    output logic [N_WAYS-1:0]              way_hit
);
    logic [N_WAYS-1:0]              lmatch;
    logic [N_WAYS-1:0][N_WAYS-1:0]  amatch;

    for (genvar t = 0; t < N_WAYS; t++) begin : g_log
        lk_cmp2 #(.W(LTAG_W), .GRP1(GRP1)) u_lc (
            .en    (req_v & tlb_v[t]),
            .a     (req_ltag),
            .b     (tlb_ltag[t]),
            .match (lmatch[t])
        );
    end

    for (genvar d = 0; d < N_WAYS; d++) begin : g_dir
        for (genvar t = 0; t < N_WAYS; t++) begin : g_tlb
            lk_cmp2 #(.W(ABS_W), .GRP1(GRP1)) u_ac (
                .en    (dir_v[d] & tlb_v[t]),
                .a     (dir_abs[d]),
                .b     (tlb_abs[t]),
                .match (amatch[d][t])
            );
        end
        assign way_hit[d] = |(amatch[d] & lmatch);
    end
endmodule

// File: rtl/l1_late_select.sv
module l1_late_select
    import l1ls_pkg::*;
#(
    parameter int IDX_W  = IDX_W_DEF,
    parameter int LTAG_W = LTAG_W_DEF,
    parameter int ABS_W  = ABS_W_DEF,
    parameter int DW_W   = DW_W_DEF,
    parameter int GRP1   = GRP1_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [IDX_W-1:0]    req_idx,
    input  logic [LTAG_W-1:0]   req_ltag,
    input  logic                wr_en,
    input  logic [1:0]          wr_kind,
    input  logic [WAY_W-1:0]    wr_way,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic [LTAG_W-1:0]   wr_ltag,
    input  logic [ABS_W-1:0]    wr_abs,
    input  logic [DW_W-1:0]     wr_data,
    output logic [N_WAYS-1:0]   late_sel_o,
    output logic                hit_o,
    output logic                multi_o,
    output logic [DW_W-1:0]     data_o
);
    // address cycle register
    logic              rq_v;
    logic [IDX_W-1:0]  rq_idx;
    logic [LTAG_W-1:0] rq_ltag;

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_v    <= 1'b0;
            rq_idx  <= '0;
            rq_ltag <= '0;
        end else begin
            rq_v    <= req_valid;
            rq_idx  <= req_idx;
            rq_ltag <= req_ltag;
        end
    end

    logic [N_WAYS-1:0]              dir_v, tlb_v;
    logic [N_WAYS-1:0][ABS_W-1:0]   dir_abs, tlb_abs;
    logic [N_WAYS-1:0][LTAG_W-1:0]  tlb_ltag;
    logic [N_WAYS-1:0][DW_W-1:0]    dw;
    logic [N_WAYS-1:0]              way_hit;

    lk_store #(.IDX_W(IDX_W), .LTAG_W(LTAG_W), .ABS_W(ABS_W), .DW_W(DW_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_kind  (fill_kind_e'(wr_kind)),
        .wr_way   (wr_way),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_ltag  (wr_ltag),
        .wr_abs   (wr_abs),
        .wr_data  (wr_data),
        .rd_idx   (rq_idx),
        .dir_v    (dir_v),
        .dir_abs  (dir_abs),
        .tlb_v    (tlb_v),
        .tlb_ltag (tlb_ltag),
        .tlb_abs  (tlb_abs),
        .dw       (dw)
    );

    lk_match #(.LTAG_W(LTAG_W), .ABS_W(ABS_W), .GRP1(GRP1)) u_match (
        .req_v    (rq_v),
        .req_ltag (rq_ltag),
        .dir_v    (dir_v),
        .dir_abs  (dir_abs),
        .tlb_v    (tlb_v),
        .tlb_ltag (tlb_ltag),
        .tlb_abs  (tlb_abs),
        .way_hit  (way_hit)
    );

    // access cycle: late select and doubleword mux
    lookup_t        lk;
    logic [DW_W-1:0] dw_pick;

    always_comb begin
        lk.sel   = lowest_way(way_hit);
        lk.hit   = |way_hit;
        lk.multi = ($countones(way_hit) > 1);
        dw_pick  = '0;
        for (int w = 0; w < N_WAYS; w++) begin
            dw_pick = dw_pick | (dw[w] & {DW_W{lk.sel[w]}});
        end
    end

    assign late_sel_o = lk.sel;

    // holding registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o   <= 1'b0;
            multi_o <= 1'b0;
            data_o  <= '0;
        end else begin
            hit_o   <= lk.hit;
            multi_o <= lk.multi;
            data_o  <= dw_pick;
        end
    end

    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(late_sel_o));

    a_r2_sel_then_hit: assert property (@(posedge clk) disable iff (rst)
        (|late_sel_o) |=> hit_o);

    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (data_o == '0) && !multi_o);

    a_r9_idle_no_sel: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (late_sel_o == '0));

    a_r6_invalid_dir_no_sel: assert property (@(posedge clk) disable iff (rst)
        (late_sel_o & ~dir_v) == '0);
endmodule

// File: tb/sim_l1_late_select.sv
`timescale 1ns/1ps
module sim_l1_late_select;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        r_v = 0;
    logic [3:0]  r_idx = 0;
    logic [51:0] r_lt = 0;
    logic        w_en = 0;
    logic [1:0]  w_kind = 0;
    logic [1:0]  w_way = 0;
    logic [3:0]  w_idx = 0;
    logic        w_v = 0;
    logic [51:0] w_lt = 0;
    logic [25:0] w_ab = 0;
    logic [63:0] w_dat = 0;
    logic [3:0]  late_sel;
    logic        hit, multi;
    logic [63:0] data;

    l1_late_select u0 (
        .clk(clk), .rst(rst), .req_valid(r_v), .req_idx(r_idx), .req_ltag(r_lt),
        .wr_en(w_en), .wr_kind(w_kind), .wr_way(w_way), .wr_idx(w_idx),
        .wr_valid(w_v), .wr_ltag(w_lt), .wr_abs(w_ab), .wr_data(w_dat),
        .late_sel_o(late_sel), .hit_o(hit), .multi_o(multi), .data_o(data)
    );

    int errors = 0;
    int checks = 0;

    // behavioural model of the stored state
    logic        m_dv [4][16];
    logic [25:0] m_da [4][16];
    logic        m_tv [4][16];
    logic [51:0] m_tl [4][16];
    logic [25:0] m_ta [4][16];
    logic [63:0] m_dd [4][16];
    logic        c_v = 0;
    logic [3:0]  c_idx = 0;
    logic [51:0] c_lt = 0;
    logic        p_hit = 0, p_multi = 0;
    logic [63:0] p_data = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ground truth lookup on the model
    task automatic model_lookup(output logic [3:0] sel, output logic h, output logic mh, output logic [63:0] d);
        int nh;
        sel = 0; h = 0; mh = 0; d = 0; nh = 0;
        if (c_v) begin
            for (int dw = 0; dw < 4; dw++) begin
                logic found;
                found = 0;
                for (int t = 0; t < 4; t++)
                    if (m_tv[t][c_idx] && m_tl[t][c_idx] == c_lt &&
                        m_dv[dw][c_idx] && m_da[dw][c_idx] == m_ta[t][c_idx])
                        found = 1;
                if (found) begin
                    if (nh == 0) begin
                        sel[dw] = 1'b1;
                        d = m_dd[dw][c_idx];
                    end
                    nh++;
                end
            end
            h = (nh > 0);
            mh = (nh > 1);
        end
    endtask

    task automatic cyc(input string tag);
        logic [3:0]  es;
        logic        eh, em;
        logic [63:0] ed;
        @(posedge clk);
        #1;
        if (w_en) begin
            case (w_kind)
                2'd0: begin m_dv[w_way][w_idx] = w_v; m_da[w_way][w_idx] = w_ab; end
                2'd1: begin m_tv[w_way][w_idx] = w_v; m_tl[w_way][w_idx] = w_lt; m_ta[w_way][w_idx] = w_ab; end
                2'd2: m_dd[w_way][w_idx] = w_dat;
                default: ;
            endcase
        end
        chk(tag, "hit_o", {63'd0, hit}, {63'd0, p_hit});
        chk(tag, "multi_o", {63'd0, multi}, {63'd0, p_multi});
        chk(tag, "data_o", data, p_data);
        c_v = r_v; c_idx = r_idx; c_lt = r_lt;
        model_lookup(es, eh, em, ed);
        chk(tag, "late_sel_o", {60'd0, late_sel}, {60'd0, es});
        p_hit = eh; p_multi = em; p_data = ed;
        r_v = 0; w_en = 0;
    endtask

    task automatic fill(input string tag, input logic [1:0] k, input logic [1:0] way, input logic [3:0] idx,
                        input logic v, input logic [51:0] lt, input logic [25:0] ab, input logic [63:0] dat);
        w_en = 1; w_kind = k; w_way = way; w_idx = idx; w_v = v; w_lt = lt; w_ab = ab; w_dat = dat;
        cyc(tag);
    endtask

    task automatic req(input string tag, input logic [3:0] idx, input logic [51:0] lt);
        r_v = 1; r_idx = idx; r_lt = lt;
        cyc(tag);
    endtask

    localparam logic [51:0] LA = 52'h8_1234_5678_9ABC;
    localparam logic [51:0] LB = 52'h0_0FED_CBA9_8765;
    localparam logic [51:0] LC = 52'h5_5555_AAAA_0001;
    localparam logic [51:0] LD = 52'hC_0000_1111_2222;
    localparam logic [25:0] X1 = 26'h2AB_CDEF;
    localparam logic [25:0] Y1 = 26'h155_0F0F;
    localparam logic [25:0] Z1 = 26'h003_3333;
    localparam logic [25:0] W1 = 26'h3FF_0001;

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 16; s++) begin
                m_dv[w][s] = 0; m_tv[w][s] = 0; m_da[w][s] = 0;
                m_ta[w][s] = 0; m_tl[w][s] = 0; m_dd[w][s] = 0;
            end
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "hit_o in reset", {63'd0, hit}, 64'd0);
        chk("R1", "data_o in reset", data, 64'd0);
        chk("R1", "multi_o in reset", {63'd0, multi}, 64'd0);
        rst = 0;
        cyc("R1");
        req("R1", 4'd2, LA);
        cyc("R1");

        // data for sets used below
        for (int w = 0; w < 4; w++) begin
            fill("R10", 2'd2, w[1:0], 4'd2, 0, 0, 0, 64'h1111_0000_0000_0000 + 64'(w));
            fill("R10", 2'd2, w[1:0], 4'd7, 0, 0, 0, 64'h7777_0000_0000_0070 + 64'(w));
            fill("R10", 2'd2, w[1:0], 4'd9, 0, 0, 0, 64'h9999_0000_0000_0900 + 64'(w));
        end

        // R4 R5: single pair hit at set 2, way 1
        fill("R10", 2'd1, 2'd0, 4'd2, 1, LA, X1, 0);
        fill("R10", 2'd0, 2'd1, 4'd2, 1, 0, X1, 0);
        req("R4", 4'd2, LA);
        cyc("R5");
        req("R2", 4'd2, LA);
        req("R2", 4'd2, LA);
        cyc("R2");

        // R3: single-bit logical differences
        req("R3", 4'd2, LA ^ 52'h1);
        req("R3", 4'd2, LA ^ (52'h1 << 51));
        req("R3", 4'd3, LA);
        cyc("R8");

        // R9: no request
        r_v = 0; r_idx = 4'd2; r_lt = LA;
        cyc("R9");
        cyc("R9");

        // R7: multi-hit
        fill("R7", 2'd0, 2'd2, 4'd2, 1, 0, X1, 0);
        req("R7", 4'd2, LA);
        cyc("R7");
        fill("R7", 2'd0, 2'd0, 4'd2, 1, 0, X1, 0);
        req("R7", 4'd2, LA);
        cyc("R7");

        // R6: invalid entries
        fill("R6", 2'd1, 2'd0, 4'd2, 0, LA, X1, 0);
        req("R6", 4'd2, LA);
        cyc("R8");
        fill("R6", 2'd1, 2'd0, 4'd2, 1, LA, X1, 0);
        for (int w = 0; w < 3; w++) fill("R6", 2'd0, w[1:0], 4'd2, 0, 0, X1, 0);
        req("R6", 4'd2, LA);
        cyc("R6");

        // R4 cross terms of the matrix at set 7
        fill("R4", 2'd1, 2'd3, 4'd7, 1, LB, Y1, 0);
        fill("R4", 2'd1, 2'd1, 4'd7, 1, LC, Z1, 0);
        fill("R4", 2'd0, 2'd0, 4'd7, 1, 0, Z1, 0);
        fill("R4", 2'd0, 2'd2, 4'd7, 1, 0, Y1, 0);
        req("R4", 4'd7, LB);
        req("R4", 4'd7, LC);
        req("R8", 4'd7, LD);
        req("R4", 4'd7, LB);
        cyc("R4");

        // R10: fill and request on the same edge
        fill("R10", 2'd1, 2'd0, 4'd9, 1, LD, W1, 0);
        r_v = 1; r_idx = 4'd9; r_lt = LD;
        fill("R10", 2'd0, 2'd3, 4'd9, 1, 0, W1, 0);
        cyc("R10");

        // back-to-back across sets
        req("R2", 4'd7, LC);
        req("R2", 4'd9, LD);
        req("R2", 4'd7, LB);
        req("R2", 4'd2, LA);
        cyc("R2");
        cyc("R2");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule